// File: doc/BRIEF.md
# RGB Pixel Packer with Optional Zero Padding

This block sits between a video source and a memory write engine. It accepts one 24-bit RGB pixel per handshake on a valid/ready stream and gathers the pixels into 128-bit words for a memory port of that width. The output is a valid/ready stream too. Frame start and end markers arrive on the input. The start marker is ignored. The end marker is used only to close out the frame, and neither marker is passed to the output.

Two layouts are offered, selected per frame. In the padded layout every pixel gets its own 4-byte slot, with a zero byte on top, so a word holds four pixels and each pixel starts on a 4-byte boundary. This makes the buffer simple to read back, at the cost of a quarter of the memory bandwidth. In the dense layout the pixels are laid end to end with no gaps, so a pixel may be split across two words and sixteen pixels fill exactly three words. When a frame ends in the middle of a word, that word is sent out with its unused bytes set to zero, and the next frame starts at byte 0 of a fresh word.

Top module: `pp_pixel_packer`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: In the padded layout (`cfg_dense`=0), pixel k of a word (k=0..3) sits in bytes 4k..4k+2 of `out_word`, with its bits 7:0 in byte 4k. Byte 4k+3 is zero. Byte n means bits 8n+7:8n, and pixel 0 of each word is the least significant.
- R3: In the dense layout (`cfg_dense`=1), the pixels of a frame form one continuous byte stream. Pixel k takes stream bytes 3k..3k+2, with its low byte first. Stream byte j goes to byte j mod 16 of word j/16. A pixel may therefore span two words, and 16 pixels give exactly 3 words.
- R4: `in_sof` has no effect on the output data. The output carries pixel bytes and zero fill only, and no marker.
- R5: When the pixel marked with `in_eof` leaves a partly filled word, that word is emitted with zero in every unused byte. When the frame ends exactly on a word boundary, no extra word is emitted. The next frame starts at byte 0.
- R6: If the last pixel of a dense frame spans two words, the completed word is emitted first. The remainder is emitted as a separate zero-filled word after it. `in_ready` stays low until the remainder has been taken.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_word` holds its value. No word is lost or duplicated under backpressure.
- R8: The layout is sampled from `cfg_dense` when the first pixel of a frame is accepted. Changes of `cfg_dense` during the rest of that frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dense | input | 1 | Layout select: 0 padded, 1 dense |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 24 | RGB pixel, low byte first in memory |
| in_sof | input | 1 | Frame start marker (ignored) |
| in_eof | input | 1 | Marks the last pixel of a frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Write engine accepts the word |
| out_word | output | 128 | Packed memory word |

## Verification
The interesting collision is a dense frame whose last pixel both completes a word and spills bytes into the next one. In that single cycle the block must emit a full word and also schedule an end-of-frame flush. The bench provokes this with six- and eleven-pixel dense frames, some of them under output backpressure. The scoreboard then judges the result: the full word and the zero-filled remainder must appear in that order, with nothing extra, and the first pixel of the following frame must land at byte 0.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int PIX_BITS  = 24;
    localparam int WORD_BITS = 128;
    localparam int SLOT_BITS = 32;

    typedef enum logic {
        PACK_PADDED = 1'b0,
        PACK_DENSE  = 1'b1
    } pack_mode_e;

    typedef enum logic [1:0] {
        EMIT_NONE    = 2'd0,
        EMIT_FULL    = 2'd1,
        EMIT_PARTIAL = 2'd2,
        EMIT_FLUSH   = 2'd3
    } emit_e;

    typedef struct packed {
        emit_e act;
        logic  clear_acc;
        logic  arm_flush;
    } step_t;

    function automatic logic [2:0] slot_bytes(pack_mode_e m);
        return (m == PACK_DENSE) ? 3'd3 : 3'd4;
    endfunction

    function automatic logic [SLOT_BITS-1:0] make_slot(logic [PIX_BITS-1:0] p);
        return SLOT_BITS'(p);
    endfunction
endpackage

// File: rtl/pp_lane_merge.sv
module pp_lane_merge #(
    parameter int WORD_W = 128,
    parameter int SLOT_W = 32,
    parameter int FILL_W = $clog2(WORD_W / 8)
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [FILL_W-1:0] fill,
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        nbytes,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] spill,
    output logic [FILL_W-1:0] new_fill,
    output logic              done
);
    localparam int BYTES  = WORD_W / 8;
    localparam int WIDE_W = 2 * WORD_W;

    logic [WIDE_W-1:0]  wide;
    logic [WIDE_W-1:0]  slot_wide;
    logic [FILL_W:0]    sum;

    always_comb begin
        slot_wide = WIDE_W'(slot) << {fill, 3'b000};
        wide      = WIDE_W'(acc) | slot_wide;
        sum       = (FILL_W+1)'(fill) + (FILL_W+1)'(nbytes);
        done      = (sum >= (FILL_W+1)'(BYTES));
        new_fill  = sum[FILL_W-1:0];
        word      = wide[WORD_W-1:0];
        spill     = wide[WIDE_W-1:WORD_W];
    end
endmodule

// File: rtl/pp_out_reg.sv
module pp_out_reg #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              free
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_word  <= load_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);
    // R7
    p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
    // R7
    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
        load |-> free);
endmodule

// File: rtl/pp_mode_latch.sv
module pp_mode_latch
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       last,
    input  pack_mode_e mode_in,
    output pack_mode_e eff_mode,
    output logic       in_frame
);
    pack_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= PACK_PADDED;
            in_frame <= 1'b0;
        end else if (accept) begin
            if (!in_frame) mode_q <= mode_in;
            in_frame <= !last;
        end
    end

    assign eff_mode = in_frame ? mode_q : mode_in;

    // R8
    p_mode_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && !last) |=> (eff_mode == $past(eff_mode)));
endmodule

// File: rtl/pp_pixel_packer.sv
module pp_pixel_packer
    import pp_pkg::*;
#(
    parameter int PIX_W  = pp_pkg::PIX_BITS,
    parameter int SLOT_W = pp_pkg::SLOT_BITS,
    parameter int WORD_W = pp_pkg::WORD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dense,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    localparam int BYTES  = WORD_W / 8;
    localparam int FILL_W = $clog2(BYTES);
    localparam int SLOTS  = WORD_W / SLOT_W;

    logic [WORD_W-1:0] acc;
    logic [FILL_W-1:0] fill;
    logic              flush_pend;
    logic              out_free;
    logic              accept;
    logic              in_frame;
    pack_mode_e        eff_mode;
    logic [WORD_W-1:0] m_word;
    logic [WORD_W-1:0] m_spill;
    logic [FILL_W-1:0] m_fill;
    logic              m_done;
    logic              load;
    logic [WORD_W-1:0] load_word;
    step_t             step;
    logic              sof_unused;

    assign sof_unused = in_sof;
    assign in_ready   = out_free && !flush_pend;
    assign accept     = in_valid && in_ready;

    pp_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .last     (in_eof),
        .mode_in  (pack_mode_e'(cfg_dense)),
        .eff_mode (eff_mode),
        .in_frame (in_frame)
    );

    pp_lane_merge #(
        .WORD_W (WORD_W),
        .SLOT_W (SLOT_W),
        .FILL_W (FILL_W)
    ) u_merge (
        .acc      (acc),
        .fill     (fill),
        .slot     (make_slot(in_pixel)),
        .nbytes   (slot_bytes(eff_mode)),
        .word     (m_word),
        .spill    (m_spill),
        .new_fill (m_fill),
        .done     (m_done)
    );

    always_comb begin
        step = '{act: EMIT_NONE, clear_acc: 1'b0, arm_flush: 1'b0};
        if (flush_pend) begin
            if (out_free) step = '{act: EMIT_FLUSH, clear_acc: 1'b1, arm_flush: 1'b0};
        end else if (accept) begin
            if (m_done) begin
                step.act = EMIT_FULL;
                if (in_eof) begin
                    step.arm_flush = (m_fill != '0);
                    step.clear_acc = (m_fill == '0);
                end
            end else if (in_eof) begin
                step.act       = (m_fill != '0) ? EMIT_PARTIAL : EMIT_NONE;
                step.clear_acc = 1'b1;
            end
        end
    end

    always_comb begin
        load      = (step.act != EMIT_NONE);
        load_word = (step.act == EMIT_FLUSH) ? acc : m_word;
    end

    pp_out_reg #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (load_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .free      (out_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            fill       <= '0;
            flush_pend <= 1'b0;
        end else begin
            if (step.clear_acc) begin
                acc  <= '0;
                fill <= '0;
            end else if (accept) begin
                acc  <= m_done ? m_spill : m_word;
                fill <= m_fill;
            end
            if (step.arm_flush)                flush_pend <= 1'b1;
            else if (step.act == EMIT_FLUSH)   flush_pend <= 1'b0;
        end
    end

    // R2: every pad byte of a word built in the padded layout is zero
    logic pads_zero;
    always_comb begin
        pads_zero = 1'b1;
        for (int s = 0; s < SLOTS; s++)
            if (m_word[s*SLOT_W+PIX_W +: (SLOT_W-PIX_W)] != '0) pads_zero = 1'b0;
    end

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && eff_mode == PACK_PADDED) |-> pads_zero);
    // R2
    p_slot_align_r2: assert property (@(posedge clk) disable iff (rst)
        (in_frame && eff_mode == PACK_PADDED) |-> (fill[1:0] == 2'b00));
    // R6
    p_flush_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        flush_pend |-> !in_ready);
    // R7
    p_stall_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    // R5
    p_frame_end_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && in_eof) |=> (!in_frame && (flush_pend || fill == '0)));
endmodule

// File: tb/pp_pixel_packer_tb_top.sv
`timescale 1ns/100ps
module pp_pixel_packer_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_dense = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [23:0]  in_pixel = '0;
    logic         in_sof = 1'b0;
    logic         in_eof = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_word;

    int checks = 0;
    int failures = 0;
    int stall_pat = 0;
    int cyc = 0;
    bit finished = 0;
    logic [127:0] exp_q[$];
    string        tag_q[$];
    bit           was_stalled = 0;
    logic [127:0] stall_word;

    always #2 clk = ~clk;

    pp_pixel_packer dut_i (
        .clk(clk), .rst(rst), .cfg_dense(cfg_dense),
        .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] pix_of(int seed, int i);
        return {8'(seed * 17 + i), 8'(i * 7 + 3), 8'(i ^ 8'hA5)};
    endfunction

    // Output backpressure pattern
    always @(negedge clk) begin
        cyc++;
        case (stall_pat)
            1:       out_ready = (cyc % 3) != 0;
            2:       out_ready = (cyc % 5) > 2;
            default: out_ready = 1'b1;
        endcase
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (was_stalled)
                check(out_valid && out_word == stall_word, "R7 word held while stalled", out_word, stall_word);
            if (out_valid && !out_ready)
                check(!in_ready, "R7 in_ready low while stalled", 128'(in_ready), 128'd0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected extra word", out_word, 128'd0);
                end else begin
                    logic [127:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_word == e, t, out_word, e);
                end
            end
            was_stalled = out_valid && !out_ready;
            stall_word  = out_word;
        end
    end

    task automatic send_frame(input bit dense, input int npix, input int seed,
                              input bit flip_mode, input bit sof_all, input string tag);
        logic [7:0] bq[$];
        while (bq.size() > 0) void'(bq.pop_front());
        for (int i = 0; i < npix; i++) begin
            logic [23:0] p;
            p = pix_of(seed, i);
            bq.push_back(p[7:0]);
            bq.push_back(p[15:8]);
            bq.push_back(p[23:16]);
            if (!dense) bq.push_back(8'h00);
        end
        while (bq.size() % 16 != 0) bq.push_back(8'h00);
        for (int w = 0; w < bq.size() / 16; w++) begin
            logic [127:0] word;
            for (int b = 0; b < 16; b++) word[8*b +: 8] = bq[16*w + b];
            exp_q.push_back(word);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < npix; i++) begin
            bit ok;
            @(negedge clk);
            cfg_dense = (flip_mode && i > 0) ? !dense : dense;
            in_valid  = 1'b1;
            in_pixel  = pix_of(seed, i);
            in_sof    = sof_all || (i == 0);
            in_eof    = (i == npix - 1);
            do begin
                #1 ok = in_ready;
                if (!ok) @(negedge clk);
            end while (!ok);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R1 out_valid in reset", 128'(out_valid), 128'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid, "R1 out_valid after reset", 128'(out_valid), 128'd0);
        check(in_ready, "R1 in_ready after reset", 128'(in_ready), 128'd1);

        stall_pat = 0;
        send_frame(0, 8, 1, 0, 0, "R2 padded two full words");
        send_frame(0, 5, 2, 0, 0, "R5 padded partial flush");
        send_frame(1, 16, 3, 0, 0, "R3 dense 16 pixels in 3 words");
        send_frame(1, 6, 4, 0, 0, "R6 dense straddle at end of frame");
        send_frame(0, 1, 5, 0, 0, "R5 single pixel frame");
        stall_pat = 1;
        send_frame(1, 11, 6, 1, 1, "R8 R4 dense with mode flip and sof noise");
        send_frame(0, 7, 7, 1, 0, "R8 padded with mode flip");
        stall_pat = 2;
        send_frame(1, 32, 8, 0, 0, "R7 dense under backpressure");
        send_frame(1, 6, 9, 0, 0, "R6 straddle under backpressure");
        send_frame(0, 9, 10, 0, 1, "R4 padded with sof on every pixel");
        stall_pat = 0;

        for (int k = 0; k < 400 && exp_q.size() > 0; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7 every word delivered", 128'(exp_q.size()), 128'd0);
        finish_run();
    end
endmodule